// File: doc/BRIEF.md
# Dual-Clock FIFO with Resynchronized Flags

This block is a 64-entry, 36-bit first-in first-out buffer whose producer and consumer run on unrelated clocks. The producer presents a word and a write enable on its own clock. The consumer raises a read enable on its clock, and the next stored word moves into a registered output. Each side sees two status flags that belong to its own clock domain. The producer sees full and almost-full. The consumer sees empty and almost-empty. All four flags are active-low: a LOW level means there is no room to write, or no data to read.

Each side keeps a binary pointer and passes it to the other side as a Gray code through a two-stage synchronizer. Because of this, a change made on one side becomes visible to the other side on the second rising edge of the observing clock. One offset, X, sets the threshold of both almost flags. X is captured from a two-bit select while reset is held. The reset is a single active-low input shared by both domains.

Top module: `dcfifo_flagsync`

## Requirements
- R1: While `rst_n` is LOW and just after it is released, `empty_n` and `aempty_n` are LOW, `full_n` and `afull_n` are HIGH, and `rdata` is zero.
- R2: Words come out on `rdata` in the order they were written, with all 36 bits intact. `rdata` changes on the rising `rclk` edge at which `ren` is HIGH and `empty_n` is HIGH.
- R3: A read requested while `empty_n` is LOW is ignored. `rdata` keeps its value, and the next word written is the next word read.
- R4: `full_n` goes LOW once 64 words are held. A write requested while it is LOW is ignored, so the rejected word is never read back.
- R5: After a write into an empty FIFO, `empty_n` stays LOW through the first rising `rclk` edge after the write and is HIGH after the second.
- R6: After a read from a full FIFO, `full_n` stays LOW through the first rising `wclk` edge after the read and is HIGH after the second. A write on the next cycle is accepted.
- R7: With the count settled, `aempty_n` is LOW for X words or fewer and HIGH for X+1 words or more.
- R8: With the count settled, `afull_n` is LOW for 64-X words or more and HIGH for 63-X words or fewer.
- R9: `xsel` is sampled while `rst_n` is LOW and sets X as follows: 0 gives 16, 1 gives 12, 2 gives 8, 3 gives 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low reset for both domains |
| xsel | input | 2 | Almost-threshold preset select, sampled during reset |
| wclk | input | 1 | Write-side clock |
| wen | input | 1 | Write request |
| wdata | input | 36 | Write data |
| full_n | output | 1 | LOW when all locations are occupied (wclk domain) |
| afull_n | output | 1 | LOW when at least 64-X words are held (wclk domain) |
| rclk | input | 1 | Read-side clock |
| ren | input | 1 | Read request |
| rdata | output | 36 | Registered read data |
| empty_n | output | 1 | LOW when no word is held (rclk domain) |
| aempty_n | output | 1 | LOW when X or fewer words are held (rclk domain) |

## Verification
The data path is driven with a short burst of distinct patterns, which include all-ones and alternating bits. A stuck or swapped bit, or a wrong order, shows up on `rdata`. A complete fill to 64 words followed by a full drain exercises pointer wrap-around. A write attempted into a full buffer and a read attempted from an empty one separate correct blocking from a pointer that slips past the limit. The almost thresholds are checked one word on each side of the boundary, once for every value of `xsel`. The release latency of empty and full is sampled edge by edge on the observing clock. This shows whether the two-stage synchronizer is present.

// File: rtl/dcfifo_flagsync.sv
module dcfifo_flagsync #(
  parameter int DW = 36,
  parameter int AW = 6
) (
  input  logic          rst_n,
  input  logic [1:0]    xsel,
  input  logic          wclk,
  input  logic          wen,
  input  logic [DW-1:0] wdata,
  output logic          full_n,
  output logic          afull_n,
  input  logic          rclk,
  input  logic          ren,
  output logic [DW-1:0] rdata,
  output logic          empty_n,
  output logic          aempty_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULLCNT = PW'(DEPTH);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] ofs;
  logic [PW-1:0] wptr, wgray, wsync1, wsync2;
  logic [PW-1:0] rptr, rgray, rsync1, rsync2;
  logic [PW-1:0] wcount, rcount, wnext, rnext;
  logic          wdo, rdo;

  // offset captured while reset is held
  always_ff @(posedge wclk)
    if (!rst_n)
      case (xsel)
        2'd0:    ofs <= PW'(DEPTH / 4);
        2'd1:    ofs <= PW'(3 * DEPTH / 16);
        2'd2:    ofs <= PW'(DEPTH / 8);
        default: ofs <= PW'(DEPTH / 16);
      endcase

  // write side
  assign wdo    = wen && full_n;
  assign wnext  = wptr + PW'(1);
  assign wcount = wptr - g2b(rsync2);
  assign full_n  = (wcount != FULLCNT);
  assign afull_n = (wcount < (FULLCNT - ofs));

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wptr   <= '0;
      wgray  <= '0;
      rsync1 <= '0;
      rsync2 <= '0;
    end else begin
      rsync1 <= rgray;
      rsync2 <= rsync1;
      if (wdo) begin
        wptr  <= wnext;
        wgray <= wnext ^ (wnext >> 1);
      end
    end

  always_ff @(posedge wclk)
    if (wdo) mem[wptr[AW-1:0]] <= wdata;

  // read side
  assign rdo    = ren && empty_n;
  assign rnext  = rptr + PW'(1);
  assign rcount = g2b(wsync2) - rptr;
  assign empty_n  = (rcount != '0);
  assign aempty_n = (rcount > ofs);

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rptr   <= '0;
      rgray  <= '0;
      wsync1 <= '0;
      wsync2 <= '0;
      rdata  <= '0;
    end else begin
      wsync1 <= wgray;
      wsync2 <= wsync1;
      if (rdo) begin
        rdata <= mem[rptr[AW-1:0]];
        rptr  <= rnext;
        rgray <= rnext ^ (rnext >> 1);
      end
    end

  assert_empty_read_hold_R3: assert property (@(posedge rclk) disable iff (!rst_n)
    (ren && !empty_n) |=> ($stable(rptr) && $stable(rdata)));
  assert_full_write_hold_R4: assert property (@(posedge wclk) disable iff (!rst_n)
    (wen && !full_n) |=> $stable(wptr));
  assert_no_overflow_R4: assert property (@(posedge wclk) disable iff (!rst_n)
    wcount <= FULLCNT);
  assert_no_underflow_R2: assert property (@(posedge rclk) disable iff (!rst_n)
    rcount <= FULLCNT);
  assert_aempty_order_R7: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);
  assert_afull_order_R8: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |-> !afull_n);
endmodule

// File: tb/test_dcfifo_flagsync.sv
module test_dcfifo_flagsync;
  localparam int WCLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 14;

  logic        rst_n = 1'b0, wclk = 1'b0, rclk = 1'b0, wen = 1'b0, ren = 1'b0;
  logic [1:0]  xsel = 2'd0;
  logic [35:0] wdata = '0;
  logic        full_n, afull_n, empty_n, aempty_n;
  logic [35:0] rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(WCLK_PERIOD / 2) wclk = ~wclk;
  always #(RCLK_PERIOD / 2) rclk = ~rclk;

  dcfifo_flagsync i_dcfifo_flagsync (
    .rst_n(rst_n), .xsel(xsel), .wclk(wclk), .wen(wen), .wdata(wdata),
    .full_n(full_n), .afull_n(afull_n), .rclk(rclk), .ren(ren),
    .rdata(rdata), .empty_n(empty_n), .aempty_n(aempty_n));

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] sel);
    @(negedge wclk);
    rst_n = 1'b0;
    xsel  = sel;
    repeat (3) @(posedge wclk);
    repeat (3) @(posedge rclk);
    @(negedge wclk);
    rst_n = 1'b1;
  endtask

  task automatic push(input logic [35:0] d);
    @(negedge wclk);
    wen = 1'b1;
    wdata = d;
    @(posedge wclk);
    #1 wen = 1'b0;
  endtask

  task automatic pop(input string tag, input logic [35:0] exp);
    @(negedge rclk);
    ren = 1'b1;
    @(posedge rclk);
    #1 ren = 1'b0;
    chk(tag, rdata, exp);
  endtask

  task automatic settle();
    repeat (3) @(posedge wclk);
    repeat (3) @(posedge rclk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge wclk);
    rst_n = 1'b0;
    #2;
    chk("R1 empty_n in reset", empty_n, 0);
    chk("R1 full_n in reset", full_n, 1);
    do_reset(2'd0);
    #1;
    chk("R1 empty_n", empty_n, 0);
    chk("R1 aempty_n", aempty_n, 0);
    chk("R1 full_n", full_n, 1);
    chk("R1 afull_n", afull_n, 1);
    chk("R1 rdata", rdata, 0);
  endtask

  task automatic t_empty_latency();
    do_reset(2'd0);
    settle();
    push(36'h123456789);
    @(posedge rclk); #1;
    chk("R5 empty_n after 1st rclk edge", empty_n, 0);
    @(posedge rclk); #1;
    chk("R5 empty_n after 2nd rclk edge", empty_n, 1);
    pop("R5 first word read", 36'h123456789);
  endtask

  task automatic t_order();
    logic [35:0] pat [8];
    pat = '{36'hFFFFFFFFF, 36'hAAAAAAAAA, 36'h555555555, 36'h000000001,
            36'h800000000, 36'h0F0F0F0F0, 36'h123456789, 36'hFEDCBA987};
    do_reset(2'd0);
    foreach (pat[i]) push(pat[i]);
    settle();
    foreach (pat[i]) pop("R2 order", pat[i]);
    settle();
    chk("R3 empty after drain", empty_n, 0);
    pop("R3 read while empty keeps rdata", pat[7]);
    push(36'h0CAFE0042);
    settle();
    pop("R3 next word after ignored read", 36'h0CAFE0042);
  endtask

  task automatic t_full();
    do_reset(2'd0);
    for (int i = 0; i < 64; i++) push(36'(i));
    push(36'hABCABCABC);
    settle();
    chk("R4 full_n at 64 words", full_n, 0);
    pop("R6 first word of full", 36'd0);
    @(posedge wclk); #1;
    chk("R6 full_n after 1st wclk edge", full_n, 0);
    @(posedge wclk); #1;
    chk("R6 full_n after 2nd wclk edge", full_n, 1);
    push(36'd64);
    chk("R6 write accepted, full again", full_n, 0);
    settle();
    for (int i = 1; i <= 64; i++) pop("R4 drain order", 36'(i));
    settle();
    chk("R4 rejected word never stored", empty_n, 0);
  endtask

  task automatic t_thresholds(input logic [1:0] sel, input int x);
    do_reset(sel);
    for (int i = 0; i < x; i++) push(36'(i));
    settle();
    chk("R7 R9 aempty_n at X words", aempty_n, 0);
    push(36'hA);
    settle();
    chk("R7 R9 aempty_n at X+1 words", aempty_n, 1);
    for (int i = x + 1; i < 63 - x; i++) push(36'(i));
    settle();
    chk("R8 R9 afull_n at 63-X words", afull_n, 1);
    push(36'hB);
    settle();
    chk("R8 R9 afull_n at 64-X words", afull_n, 0);
  endtask

  initial begin
    #(WCLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_empty_latency();
    t_order();
    t_full();
    t_thresholds(2'd0, 16);
    t_thresholds(2'd1, 12);
    t_thresholds(2'd2, 8);
    t_thresholds(2'd3, 4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule